// File: doc/BRIEF.md
# Bufferless Two-Ring Stop

This block is one stop on a pair of counter-rotating rings: one ring moves flits clockwise, the other counter-clockwise. Every cycle it takes the slot arriving on each ring. A flit addressed to this stop is moved into a small local eject queue if the queue has room. A flit for another stop goes on to the next stop one cycle later. Nothing is held on the ring itself. If a flit reaches its destination while the eject queue is full, it stays on its ring and comes back after a full lap. A counter in the flit records how often that has happened.

Local traffic enters through a valid/ready port that carries a destination and a payload. The stop picks the ring with the fewer hops to the destination and places the message only into a slot that is empty in that cycle. A slot counts as empty when no flit arrives in it, or when the arriving flit is ejected here. The eject side shows the oldest queued payload and its source. The consumer removes it with a pop strobe, and a full flag shows when the queue cannot take more.

Top module: `ring_stop`

## Requirements
- R1: While reset is low and in the first cycle after it, both ring outputs are invalid, `ej_vld` is 0 and `ej_full` is 0.
- R2: A valid input flit whose destination differs from `MY_ID` appears on the same ring's output one cycle later with destination, source, bounce count and payload unchanged.
- R3: A valid input flit addressed to `MY_ID` that finds room is taken off the ring. Its payload and source enter the eject queue and are visible at the eject port after the clock edge. The ring output then carries no flit unless a local message is injected into that slot.
- R4: A flit addressed to `MY_ID` that finds no room is forwarded on its ring with its bounce count increased by one. The count saturates at all-ones.
- R5: When both rings deliver a flit for `MY_ID` in the same cycle and only one queue entry is free, the clockwise flit is ejected and the counter-clockwise flit bounces.
- R6: With clockwise hop distance d = (dst - MY_ID) mod NODES, injection uses the clockwise ring when d <= NODES - d, and the counter-clockwise ring otherwise. A tie therefore goes clockwise.
- R7: A ring flit always wins its slot over local injection. `inj_rdy` is 1 only when the chosen ring's slot is empty or is being ejected in that cycle. An injected flit leaves one cycle later with source `MY_ID`, bounce count 0, and the requested destination and payload.
- R8: A local message addressed to `MY_ID` itself is never accepted (`inj_rdy` stays 0).
- R9: The eject queue holds `EJ_DEPTH` entries in arrival order, with the clockwise flit ahead of the counter-clockwise one when both arrive in the same cycle. `ej_pop` with `ej_vld` removes the head. `ej_full` is 1 when the queue holds `EJ_DEPTH` entries. An entry freed by a pop accepts a flit only from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cw_in_vld | input | 1 | Clockwise slot arriving holds a flit |
| cw_in_dst | input | NODE_W | Destination of arriving clockwise flit |
| cw_in_src | input | NODE_W | Source of arriving clockwise flit |
| cw_in_bnc | input | BNC_W | Bounce count of arriving clockwise flit |
| cw_in_data | input | DATA_W | Payload of arriving clockwise flit |
| ccw_in_vld | input | 1 | Counter-clockwise slot arriving holds a flit |
| ccw_in_dst | input | NODE_W | Destination of arriving counter-clockwise flit |
| ccw_in_src | input | NODE_W | Source of arriving counter-clockwise flit |
| ccw_in_bnc | input | BNC_W | Bounce count of arriving counter-clockwise flit |
| ccw_in_data | input | DATA_W | Payload of arriving counter-clockwise flit |
| cw_out_vld | output | 1 | Clockwise slot leaving holds a flit |
| cw_out_dst | output | NODE_W | Destination of leaving clockwise flit |
| cw_out_src | output | NODE_W | Source of leaving clockwise flit |
| cw_out_bnc | output | BNC_W | Bounce count of leaving clockwise flit |
| cw_out_data | output | DATA_W | Payload of leaving clockwise flit |
| ccw_out_vld | output | 1 | Counter-clockwise slot leaving holds a flit |
| ccw_out_dst | output | NODE_W | Destination of leaving counter-clockwise flit |
| ccw_out_src | output | NODE_W | Source of leaving counter-clockwise flit |
| ccw_out_bnc | output | BNC_W | Bounce count of leaving counter-clockwise flit |
| ccw_out_data | output | DATA_W | Payload of leaving counter-clockwise flit |
| inj_vld | input | 1 | Local message offered |
| inj_rdy | output | 1 | Local message accepted this cycle |
| inj_dst | input | NODE_W | Destination of local message |
| inj_data | input | DATA_W | Payload of local message |
| ej_vld | output | 1 | Eject queue head is valid |
| ej_data | output | DATA_W | Payload at queue head |
| ej_src | output | NODE_W | Source at queue head |
| ej_full | output | 1 | Eject queue is full |
| ej_pop | input | 1 | Remove queue head |

## Verification
An error in the eject-queue count shows at the ring outputs in the next cycle. A flit addressed here then bounces while the queue has room, or is accepted while the queue is full and overwrites a queued entry. The overwrite surfaces later as a wrong payload or order at the eject port when the queue is drained. A wrong hop-direction result shows up one cycle after injection, as the flit leaving on the wrong ring. A wrong slot-vacancy result shows up as `inj_rdy` rising while a passing flit occupies the slot, and the next cycle one of the two flits is missing. The bench sweeps every destination on a six-stop ring with a two-entry queue. It compares each output one cycle after stimulus against values computed from the hop arithmetic and the queue occupancy.

// File: rtl/ring_stop_pkg.sv
// Shared helpers for the ring stop.
// Assumes node IDs are 0..NODES-1 and numbered in clockwise order.
package ring_stop_pkg;

    // Clockwise hop distance from node me to node dst on a ring of n nodes.
    function automatic int unsigned cw_hops(input int unsigned dst,
                                            input int unsigned me,
                                            input int unsigned n);
        return (dst + n - me) % n;
    endfunction

    // Ring choice: clockwise on shorter or equal distance.
    function automatic logic pick_cw(input int unsigned dst,
                                     input int unsigned me,
                                     input int unsigned n);
        int unsigned d;
        d = cw_hops(dst, me, n);
        return (d <= n - d);
    endfunction

endpackage

// File: rtl/ring_stop_lane.sv
// One ring direction at a stop: detects flits for this node, forwards
// or bounces the rest, and places an injected flit into a vacated slot.
// Assumes the parent never asserts ins when vacant is low.
module ring_stop_lane #(
    parameter int NODES  = 8,
    parameter int MY_ID  = 0,
    parameter int DATA_W = 16,
    parameter int BNC_W  = 4,
    localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [NODE_W-1:0] in_dst,
    input  logic [NODE_W-1:0] in_src,
    input  logic [BNC_W-1:0]  in_bnc,
    input  logic [DATA_W-1:0] in_data,
    input  logic              take,
    input  logic              ins,
    input  logic [NODE_W-1:0] ins_dst,
    input  logic [DATA_W-1:0] ins_data,
    output logic              hit,
    output logic              vacant,
    output logic              out_vld,
    output logic [NODE_W-1:0] out_dst,
    output logic [NODE_W-1:0] out_src,
    output logic [BNC_W-1:0]  out_bnc,
    output logic [DATA_W-1:0] out_data
);

    localparam logic [NODE_W-1:0] SELF = NODE_W'(MY_ID);

    // Slot decode: addressed here, and free for injection.
    always_comb begin
        hit    = in_vld && (in_dst == SELF);
        vacant = !in_vld || take;
    end

    // Output slot register: inject, forward/bounce, or empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_dst  <= '0;
            out_src  <= '0;
            out_bnc  <= '0;
            out_data <= '0;
        end else if (ins) begin
            out_vld  <= 1'b1;
            out_dst  <= ins_dst;
            out_src  <= SELF;
            out_bnc  <= '0;
            out_data <= ins_data;
        end else if (in_vld && !take) begin
            out_vld  <= 1'b1;
            out_dst  <= in_dst;
            out_src  <= in_src;
            out_data <= in_data;
            if (hit && (in_bnc != '1))
                out_bnc <= in_bnc + 1'b1;
            else
                out_bnc <= in_bnc;
        end else begin
            out_vld  <= 1'b0;
        end
    end

endmodule

// File: rtl/ring_stop_ejq.sv
// Local eject queue accepting up to two entries per cycle (port 0 first).
// Assumes the parent writes only into free entries as reported by cnt.
module ring_stop_ejq #(
    parameter int DEPTH = 4,
    parameter int ENT_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr0,
    input  logic [ENT_W-1:0] d0,
    input  logic             wr1,
    input  logic [ENT_W-1:0] d1,
    input  logic             pop,
    output logic             vld,
    output logic [ENT_W-1:0] head,
    output logic [CNT_W-1:0] cnt
);

    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             pop_do;

    // Pointer advance with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    // Head view and pop qualification.
    always_comb begin
        vld    = (cnt != '0);
        head   = mem[rp];
        pop_do = pop && vld;
    end

    // Entry storage writes.
    always_ff @(posedge clk) begin
        if (wr0 || wr1)
            mem[wp] <= wr0 ? d0 : d1;
        if (wr0 && wr1)
            mem[nxt(wp)] <= d1;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr0 && wr1)
                wp <= nxt(nxt(wp));
            else if (wr0 || wr1)
                wp <= nxt(wp);
            if (pop_do)
                rp <= nxt(rp);
            cnt <= cnt + CNT_W'(wr0) + CNT_W'(wr1) - CNT_W'(pop_do);
        end
    end

endmodule

// File: rtl/ring_stop.sv
// Stop on two counter-rotating bufferless rings. Ejects flits for MY_ID
// while the local queue has room (clockwise first), bounces the rest, and
// injects local messages on the shorter ring into empty slots only.
// Assumes ring neighbours present one slot per ring per cycle.
module ring_stop
    import ring_stop_pkg::*;
#(
    parameter int NODES    = 8,
    parameter int MY_ID    = 0,
    parameter int DATA_W   = 16,
    parameter int BNC_W    = 4,
    parameter int EJ_DEPTH = 4,
    localparam int NODE_W  = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int CNT_W   = $clog2(EJ_DEPTH + 1),
    localparam int ENT_W   = NODE_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_in_vld,
    input  logic [NODE_W-1:0] cw_in_dst,
    input  logic [NODE_W-1:0] cw_in_src,
    input  logic [BNC_W-1:0]  cw_in_bnc,
    input  logic [DATA_W-1:0] cw_in_data,
    input  logic              ccw_in_vld,
    input  logic [NODE_W-1:0] ccw_in_dst,
    input  logic [NODE_W-1:0] ccw_in_src,
    input  logic [BNC_W-1:0]  ccw_in_bnc,
    input  logic [DATA_W-1:0] ccw_in_data,
    output logic              cw_out_vld,
    output logic [NODE_W-1:0] cw_out_dst,
    output logic [NODE_W-1:0] cw_out_src,
    output logic [BNC_W-1:0]  cw_out_bnc,
    output logic [DATA_W-1:0] cw_out_data,
    output logic              ccw_out_vld,
    output logic [NODE_W-1:0] ccw_out_dst,
    output logic [NODE_W-1:0] ccw_out_src,
    output logic [BNC_W-1:0]  ccw_out_bnc,
    output logic [DATA_W-1:0] ccw_out_data,
    input  logic              inj_vld,
    output logic              inj_rdy,
    input  logic [NODE_W-1:0] inj_dst,
    input  logic [DATA_W-1:0] inj_data,
    output logic              ej_vld,
    output logic [DATA_W-1:0] ej_data,
    output logic [NODE_W-1:0] ej_src,
    output logic              ej_full,
    input  logic              ej_pop
);

    localparam int LANES = 2;   // index 0 clockwise, 1 counter-clockwise

    logic              l_in_vld  [LANES];
    logic [NODE_W-1:0] l_in_dst  [LANES];
    logic [NODE_W-1:0] l_in_src  [LANES];
    logic [BNC_W-1:0]  l_in_bnc  [LANES];
    logic [DATA_W-1:0] l_in_data [LANES];
    logic              l_out_vld [LANES];
    logic [NODE_W-1:0] l_out_dst [LANES];
    logic [NODE_W-1:0] l_out_src [LANES];
    logic [BNC_W-1:0]  l_out_bnc [LANES];
    logic [DATA_W-1:0] l_out_data[LANES];
    logic [LANES-1:0]  hit, take, vacant, ins;
    logic [CNT_W-1:0]  q_cnt;
    logic [ENT_W-1:0]  q_head, ent0, ent1;
    logic              inj_cw, self_dst, q_wr0, q_wr1;

    // Gather ring inputs and scatter ring outputs per lane.
    always_comb begin
        l_in_vld[0] = cw_in_vld;   l_in_dst[0] = cw_in_dst;   l_in_src[0] = cw_in_src;
        l_in_bnc[0] = cw_in_bnc;   l_in_data[0] = cw_in_data;
        l_in_vld[1] = ccw_in_vld;  l_in_dst[1] = ccw_in_dst;  l_in_src[1] = ccw_in_src;
        l_in_bnc[1] = ccw_in_bnc;  l_in_data[1] = ccw_in_data;
        cw_out_vld  = l_out_vld[0]; cw_out_dst  = l_out_dst[0]; cw_out_src  = l_out_src[0];
        cw_out_bnc  = l_out_bnc[0]; cw_out_data = l_out_data[0];
        ccw_out_vld = l_out_vld[1]; ccw_out_dst = l_out_dst[1]; ccw_out_src = l_out_src[1];
        ccw_out_bnc = l_out_bnc[1]; ccw_out_data = l_out_data[1];
    end

    // Eject arbitration: clockwise takes the first free entry.
    always_comb begin
        take[0] = hit[0] && (32'(q_cnt) < EJ_DEPTH);
        take[1] = hit[1] && (32'(q_cnt) + 32'(take[0]) < EJ_DEPTH);
    end

    // Injection: shorter ring, only into a vacant slot, never to self.
    always_comb begin
        self_dst = (inj_dst == NODE_W'(MY_ID));
        inj_cw   = pick_cw(32'(inj_dst), MY_ID, NODES);
        inj_rdy  = !self_dst && (inj_cw ? vacant[0] : vacant[1]);
        ins[0]   = inj_vld && inj_rdy && inj_cw;
        ins[1]   = inj_vld && inj_rdy && !inj_cw;
    end

    // Queue write ports: first accepted flit to port 0.
    always_comb begin
        q_wr0 = take[0] || take[1];
        q_wr1 = take[0] && take[1];
        ent0  = take[0] ? {cw_in_src, cw_in_data} : {ccw_in_src, ccw_in_data};
        ent1  = {ccw_in_src, ccw_in_data};
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            ring_stop_lane #(
                .NODES(NODES), .MY_ID(MY_ID), .DATA_W(DATA_W), .BNC_W(BNC_W)
            ) u_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .in_vld   (l_in_vld[g]),
                .in_dst   (l_in_dst[g]),
                .in_src   (l_in_src[g]),
                .in_bnc   (l_in_bnc[g]),
                .in_data  (l_in_data[g]),
                .take     (take[g]),
                .ins      (ins[g]),
                .ins_dst  (inj_dst),
                .ins_data (inj_data),
                .hit      (hit[g]),
                .vacant   (vacant[g]),
                .out_vld  (l_out_vld[g]),
                .out_dst  (l_out_dst[g]),
                .out_src  (l_out_src[g]),
                .out_bnc  (l_out_bnc[g]),
                .out_data (l_out_data[g])
            );
        end
    endgenerate

    ring_stop_ejq #(.DEPTH(EJ_DEPTH), .ENT_W(ENT_W)) u_ejq (
        .clk   (clk),
        .rst_n (rst_n),
        .wr0   (q_wr0),
        .d0    (ent0),
        .wr1   (q_wr1),
        .d1    (ent1),
        .pop   (ej_pop),
        .vld   (ej_vld),
        .head  (q_head),
        .cnt   (q_cnt)
    );

    // Eject port view.
    always_comb begin
        ej_src  = q_head[ENT_W-1:DATA_W];
        ej_data = q_head[DATA_W-1:0];
        ej_full = (32'(q_cnt) == EJ_DEPTH);
    end

endmodule

// File: rtl/ring_stop_chk.sv
// Port-level properties of the ring stop, attached by bind.
module ring_stop_chk #(
    parameter int NODES  = 8,
    parameter int MY_ID  = 0,
    parameter int DATA_W = 16,
    parameter int BNC_W  = 4,
    localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cw_in_vld,
    input logic [NODE_W-1:0] cw_in_dst,
    input logic [NODE_W-1:0] cw_in_src,
    input logic [BNC_W-1:0]  cw_in_bnc,
    input logic [DATA_W-1:0] cw_in_data,
    input logic              ccw_in_vld,
    input logic [NODE_W-1:0] ccw_in_dst,
    input logic [DATA_W-1:0] ccw_in_data,
    input logic              cw_out_vld,
    input logic [NODE_W-1:0] cw_out_src,
    input logic [BNC_W-1:0]  cw_out_bnc,
    input logic [DATA_W-1:0] cw_out_data,
    input logic              ccw_out_vld,
    input logic [NODE_W-1:0] ccw_out_src,
    input logic [BNC_W-1:0]  ccw_out_bnc,
    input logic [DATA_W-1:0] ccw_out_data,
    input logic              inj_vld,
    input logic              inj_rdy,
    input logic [NODE_W-1:0] inj_dst,
    input logic              ej_vld,
    input logic              ej_full,
    input logic              ej_pop
);

    localparam logic [NODE_W-1:0] SELF = NODE_W'(MY_ID);

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!cw_out_vld && !ccw_out_vld && !ej_vld));              // R1
    AST_FWD_CW: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_in_vld && cw_in_dst != SELF) |=>
        (cw_out_vld && cw_out_src == $past(cw_in_src) && cw_out_bnc == $past(cw_in_bnc)
         && cw_out_data == $past(cw_in_data)));                                      // R2
    AST_FWD_CCW: assert property (@(posedge clk) disable iff (!rst_n)
        (ccw_in_vld && ccw_in_dst != SELF) |=>
        (ccw_out_vld && ccw_out_data == $past(ccw_in_data)));                        // R2
    AST_BOUNCE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (ej_full && cw_in_vld && cw_in_dst == SELF && cw_in_bnc != '1) |=>
        (cw_out_vld && cw_out_bnc == $past(cw_in_bnc) + 1'b1));                      // R4
    AST_RDY_VACANT: assert property (@(posedge clk) disable iff (!rst_n)
        inj_rdy |-> (!cw_in_vld || cw_in_dst == SELF || !ccw_in_vld || ccw_in_dst == SELF)); // R7
    AST_INJ_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_vld && inj_rdy) |=>
        ((cw_out_vld && cw_out_src == SELF && cw_out_bnc == '0) ||
         (ccw_out_vld && ccw_out_src == SELF && ccw_out_bnc == '0)));                // R7
    AST_SELF_INJ: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_dst == SELF) |-> !inj_rdy);                                             // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ej_full && !ej_pop) |=> ej_full);                                           // R9

endmodule

bind ring_stop ring_stop_chk #(
    .NODES(NODES), .MY_ID(MY_ID), .DATA_W(DATA_W), .BNC_W(BNC_W)
) u_chk (.*);

// File: tb/ring_stop_tb.sv
module ring_stop_tb;

    localparam int N  = 6;
    localparam int ID = 2;
    localparam int DW = 8;
    localparam int BW = 2;
    localparam int DP = 2;
    localparam int NW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cw_in_vld, ccw_in_vld, inj_vld, ej_pop;
    logic [NW-1:0] cw_in_dst, cw_in_src, ccw_in_dst, ccw_in_src, inj_dst;
    logic [BW-1:0] cw_in_bnc, ccw_in_bnc;
    logic [DW-1:0] cw_in_data, ccw_in_data, inj_data;
    logic cw_out_vld, ccw_out_vld, inj_rdy, ej_vld, ej_full;
    logic [NW-1:0] cw_out_dst, cw_out_src, ccw_out_dst, ccw_out_src, ej_src;
    logic [BW-1:0] cw_out_bnc, ccw_out_bnc;
    logic [DW-1:0] cw_out_data, ccw_out_data, ej_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    ring_stop #(.NODES(N), .MY_ID(ID), .DATA_W(DW), .BNC_W(BW), .EJ_DEPTH(DP)) u_dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cw_in_vld = 0; cw_in_dst = 0; cw_in_src = 0; cw_in_bnc = 0; cw_in_data = 0;
        ccw_in_vld = 0; ccw_in_dst = 0; ccw_in_src = 0; ccw_in_bnc = 0; ccw_in_data = 0;
        inj_vld = 0; inj_dst = 0; inj_data = 0; ej_pop = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) tick();
        check(!cw_out_vld && !ccw_out_vld, "R1 ring outputs in reset", cw_out_vld, 0);
        check(!ej_vld && !ej_full, "R1 eject idle in reset", ej_vld, 0);
        rst_n = 1;
        tick();
        check(!cw_out_vld && !ccw_out_vld && !ej_vld, "R1 after reset", ccw_out_vld, 0);

        // Injection sweep over every destination on empty rings.
        for (int d = 0; d < N; d++) begin
            int hops;
            bit want_cw, want_rdy;
            hops     = (d + N - ID) % N;
            want_cw  = (hops <= N - hops);
            want_rdy = (d != ID);
            inj_vld = 1; inj_dst = NW'(d); inj_data = DW'(8'h40 + d);
            #1;
            check(inj_rdy == want_rdy, want_rdy ? "R7 rdy empty slot" : "R8 self dst",
                  inj_rdy, want_rdy);
            tick();
            inj_vld = 0;
            if (!want_rdy)
                check(!cw_out_vld && !ccw_out_vld, "R8 nothing injected", cw_out_vld, 0);
            else if (want_cw)
                check(cw_out_vld && !ccw_out_vld && cw_out_dst == NW'(d) && cw_out_src == NW'(ID)
                      && cw_out_bnc == 0 && cw_out_data == DW'(8'h40 + d),
                      "R6 cw pick", cw_out_data, 8'h40 + d);
            else
                check(ccw_out_vld && !cw_out_vld && ccw_out_dst == NW'(d) && ccw_out_src == NW'(ID)
                      && ccw_out_bnc == 0 && ccw_out_data == DW'(8'h40 + d),
                      "R6 ccw pick", ccw_out_data, 8'h40 + d);
        end
        tick();

        // Pass-through sweep on both rings at once.
        for (int d = 0; d < N; d++) begin
            if (d != ID) begin
                cw_in_vld = 1; cw_in_dst = NW'(d); cw_in_src = NW'((d + 1) % N);
                cw_in_bnc = 1; cw_in_data = DW'(8'h10 + d);
                ccw_in_vld = 1; ccw_in_dst = NW'(d); ccw_in_src = NW'((d + 3) % N);
                ccw_in_bnc = 2; ccw_in_data = DW'(8'h20 + d);
                tick();
                check(cw_out_vld && cw_out_dst == NW'(d) && cw_out_src == NW'((d + 1) % N)
                      && cw_out_bnc == 1 && cw_out_data == DW'(8'h10 + d),
                      "R2 cw forward", cw_out_data, 8'h10 + d);
                check(ccw_out_vld && ccw_out_dst == NW'(d) && ccw_out_src == NW'((d + 3) % N)
                      && ccw_out_bnc == 2 && ccw_out_data == DW'(8'h20 + d),
                      "R2 ccw forward", ccw_out_data, 8'h20 + d);
                check(!ej_vld, "R2 no eject", ej_vld, 0);
            end
        end
        idle();

        // Occupied clockwise slot blocks a clockwise-bound injection.
        cw_in_vld = 1; cw_in_dst = 4; cw_in_src = 1; cw_in_data = 8'h77;
        inj_vld = 1; inj_dst = 3; inj_data = 8'h99;
        #1;
        check(!inj_rdy, "R7 ring flit wins slot", inj_rdy, 0);
        tick();
        check(cw_out_vld && cw_out_data == 8'h77 && cw_out_src == 1, "R7 passing flit kept",
              cw_out_data, 8'h77);
        inj_dst = 0;
        #1;
        check(inj_rdy, "R7 other ring free", inj_rdy, 1);
        tick();
        check(ccw_out_vld && ccw_out_data == 8'h99 && ccw_out_dst == 0, "R7 ccw inject",
              ccw_out_data, 8'h99);
        idle();

        // Eject frees the clockwise slot for an injection in the same cycle.
        cw_in_vld = 1; cw_in_dst = NW'(ID); cw_in_src = 5; cw_in_data = 8'hA1;
        inj_vld = 1; inj_dst = 3; inj_data = 8'h55;
        #1;
        check(inj_rdy, "R7 ejected slot reusable", inj_rdy, 1);
        tick();
        idle();
        check(ej_vld && ej_data == 8'hA1 && ej_src == 5, "R3 eject", ej_data, 8'hA1);
        check(cw_out_vld && cw_out_data == 8'h55 && cw_out_src == NW'(ID), "R3 slot refilled",
              cw_out_data, 8'h55);

        // Two hits with one free entry: clockwise wins, ccw bounces saturated.
        cw_in_vld = 1; cw_in_dst = NW'(ID); cw_in_src = 1; cw_in_data = 8'hB1;
        ccw_in_vld = 1; ccw_in_dst = NW'(ID); ccw_in_src = 3; ccw_in_bnc = 3; ccw_in_data = 8'hC1;
        tick();
        idle();
        check(ej_full, "R9 full at depth", ej_full, 1);
        check(!cw_out_vld, "R5 cw taken", cw_out_vld, 0);
        check(ccw_out_vld && ccw_out_data == 8'hC1 && ccw_out_dst == NW'(ID),
              "R5 ccw bounced", ccw_out_data, 8'hC1);
        check(ccw_out_bnc == 3, "R4 bounce saturates", ccw_out_bnc, 3);

        // Full queue with pop in the same cycle: still bounces.
        cw_in_vld = 1; cw_in_dst = NW'(ID); cw_in_src = 4; cw_in_bnc = 1; cw_in_data = 8'hD1;
        ej_pop = 1;
        #1;
        check(ej_data == 8'hA1, "R9 head oldest", ej_data, 8'hA1);
        tick();
        idle();
        check(cw_out_vld && cw_out_bnc == 2 && cw_out_data == 8'hD1, "R4 bounce increments",
              cw_out_bnc, 2);
        check(ej_vld && !ej_full && ej_data == 8'hB1 && ej_src == 1, "R9 pop order",
              ej_data, 8'hB1);
        ej_pop = 1;
        tick();
        ej_pop = 0;
        check(!ej_vld, "R9 drained", ej_vld, 0);

        // Two hits with room for both: cw entry ahead of ccw entry.
        cw_in_vld = 1; cw_in_dst = NW'(ID); cw_in_src = 0; cw_in_data = 8'hE1;
        ccw_in_vld = 1; ccw_in_dst = NW'(ID); ccw_in_src = 5; ccw_in_data = 8'hF1;
        tick();
        idle();
        check(!cw_out_vld && !ccw_out_vld, "R3 both removed", ccw_out_vld, 0);
        check(ej_data == 8'hE1 && ej_src == 0 && ej_full, "R9 cw first", ej_data, 8'hE1);
        ej_pop = 1;
        tick();
        ej_pop = 0;
        check(ej_vld && ej_data == 8'hF1 && ej_src == 5, "R9 ccw second", ej_data, 8'hF1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule